// File: doc/BRIEF.md
# Program Fetch Strobe Generator

This block drives the active-low read strobe for an off-chip program store. For every code fetch it also decides whether the bytes come from the on-chip program memory or from the external one. The sequencer supplies a phase count that steps through the twelve oscillator phases of each machine cycle. It also supplies the program counter, the level of the on-chip enable pin, and a flag that marks a machine cycle spending its bus time on an external data-memory access.

In a normal off-chip fetch cycle the strobe falls twice, once in each half of the machine cycle. When the cycle carries an external data access, both pulses are withheld so that the bus is left to the data transfer. When the on-chip enable pin is high, addresses up to the on-chip limit are served internally and produce no strobe. Addresses above that limit go off-chip. When the pin is low, every address goes off-chip. The source is decided again at the start of each strobe window, so the two fetches of a single machine cycle can fall on different sides of the boundary.

Top module: `code_fetch_strobe`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the strobe output is high and the off-chip select output is low.
- R2: With the default settings, the strobe shows exactly two low pulses in a machine cycle whose fetches are off-chip. Each pulse is three phases long. The strobe output is low in the clock that follows each phase input value in 3..5 and in 9..11, and high for every other phase value.
- R3: If the data-access flag is high when the phase input is 0, the strobe stays high for the rest of that machine cycle, whatever the fetch source.
- R4: The strobe never goes low for a window whose fetch source is on-chip.
- R5: With the on-chip enable input at 1, a program counter at or below 0x1FFF selects on-chip (select output 0), and a value of 0x2000 or above selects off-chip (select output 1).
- R6: With the on-chip enable input at 0, every program counter value selects off-chip.
- R7: The source decision is sampled only when the phase input equals a window start (3 or 9). The select output takes the new value in the following clock and holds it at all other phases. A program counter that changes between the two windows therefore affects only the second window.
- R8: Phase input values 12 to 15 produce no strobe pulse and leave the select output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-phase clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 4 | Phase within the machine cycle, 0..11 |
| pc_i | input | 16 | Program counter of the current fetch |
| onchip_en_i | input | 1 | High: addresses up to the limit are served on-chip |
| xdata_cycle_i | input | 1 | Machine cycle carries an external data access (sampled at phase 0) |
| fetch_strobe_n_o | output | 1 | Active-low off-chip program read strobe |
| fetch_offchip_o | output | 1 | 1 when the current fetch is served off-chip |

## Verification
The bench builds the block with its default parameters: a 4-bit phase, a 16-bit program counter, a twelve-phase cycle with two three-phase windows at phases 3 and 9, a registered output, and an on-chip limit of 0x1FFF. These values bring the exact boundary pair 0x1FFF/0x2000 within reach. They also allow a mid-cycle program counter change that moves the second window across the boundary, and the unused phase codes 12 to 15 that the 4-bit counter can still present. Random cycles are biased toward the boundary and mix both pin levels and the data-access flag.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

   typedef enum logic {
      SRC_ONCHIP  = 1'b0,
      SRC_OFFCHIP = 1'b1
   } fetch_src_e;

   typedef struct packed {
      logic in_window;
      logic pulse_start;
      logic cycle_start;
   } phase_hits_t;

endpackage

// File: rtl/cfs_phase_decode.sv
module cfs_phase_decode
   import cfs_pkg::*;
#(
   parameter int PH_W         = 4,
   parameter int CYCLE_PHASES = 12,
   parameter int NUM_PULSES   = 2,
   parameter int PULSE_OFFSET = 3,
   parameter int PULSE_LEN    = 3
) (
   input  logic [PH_W-1:0] phase_i,
   output phase_hits_t     hits_o
);

   localparam int SPACING  = CYCLE_PHASES / NUM_PULSES;
   localparam int LAST_END = PULSE_OFFSET + (NUM_PULSES - 1) * SPACING + PULSE_LEN;

   if (CYCLE_PHASES > (1 << PH_W)) begin : g_bad_width
      $error("phase counter too narrow for the machine cycle");
   end
   if (PULSE_LEN < 1 || PULSE_LEN > SPACING) begin : g_bad_len
      $error("strobe window must fit inside its share of the cycle");
   end
   if (PULSE_OFFSET < 1 || LAST_END > CYCLE_PHASES) begin : g_bad_offset
      $error("strobe windows must lie inside phases 1..CYCLE_PHASES-1");
   end

   logic [NUM_PULSES-1:0] win_hit;
   logic [NUM_PULSES-1:0] start_hit;

   for (genvar k = 0; k < NUM_PULSES; k++) begin : g_window
      localparam int              START = PULSE_OFFSET + k * SPACING;
      localparam logic [PH_W-1:0] FIRST = PH_W'(START);
      localparam logic [PH_W-1:0] LAST  = PH_W'(START + PULSE_LEN - 1);

      assign win_hit[k]   = (phase_i >= FIRST) && (phase_i <= LAST);
      assign start_hit[k] = (phase_i == FIRST);
   end

   always_comb begin
      hits_o.in_window   = |win_hit;
      hits_o.pulse_start = |start_hit;
      hits_o.cycle_start = (phase_i == '0);
   end

endmodule

// File: rtl/cfs_source_select.sv
module cfs_source_select
   import cfs_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int ONCHIP_TOP = 'h1FFF
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PC_W-1:0] pc_i,
   input  logic            onchip_en_i,
   input  logic            eval_i,
   output fetch_src_e      src_now_o,
   output fetch_src_e      src_q_o
);

   localparam logic [PC_W-1:0] TOP_V = PC_W'(ONCHIP_TOP);

   if (PC_W < 2 || PC_W > 32) begin : g_bad_pc
      $error("program counter width out of range");
   end

   always_comb begin
      if (!onchip_en_i || (pc_i > TOP_V)) src_now_o = SRC_OFFCHIP;
      else                                src_now_o = SRC_ONCHIP;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     src_q_o <= SRC_ONCHIP;
      else if (eval_i) src_q_o <= src_now_o;
   end

   AST_PIN_LOW_OFFCHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && !onchip_en_i) |=> (src_q_o == SRC_OFFCHIP));                 // R6
   AST_BOUNDARY_ONCHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && onchip_en_i && (pc_i <= TOP_V)) |=> (src_q_o == SRC_ONCHIP)); // R5
   AST_ABOVE_OFFCHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && (pc_i > TOP_V)) |=> (src_q_o == SRC_OFFCHIP));               // R5
   AST_DECISION_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eval_i |=> $stable(src_q_o));                                          // R7

endmodule

// File: rtl/cfs_strobe_gate.sv
module cfs_strobe_gate
   import cfs_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       in_window_i,
   input  logic       cycle_start_i,
   input  fetch_src_e src_i,
   input  logic       xdata_cycle_i,
   output logic       strobe_n_o
);

   logic xdata_q;
   logic xdata_eff;
   logic drive_low;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)            xdata_q <= 1'b0;
      else if (cycle_start_i) xdata_q <= xdata_cycle_i;
   end

   assign xdata_eff = cycle_start_i ? xdata_cycle_i : xdata_q;
   assign drive_low = in_window_i && (src_i == SRC_OFFCHIP) && !xdata_eff;

   if (OUT_REG) begin : g_registered
      logic strobe_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) strobe_q <= 1'b1;
         else         strobe_q <= !drive_low;
      end
      assign strobe_n_o = strobe_q;

      AST_XDATA_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(xdata_eff) |-> strobe_n_o);                                    // R3
      AST_ONCHIP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(src_i) == SRC_ONCHIP) |-> strobe_n_o);                        // R4
   end else begin : g_combinational
      assign strobe_n_o = !drive_low;

      AST_XDATA_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         xdata_eff |-> strobe_n_o);                                           // R3
   end

endmodule

// File: rtl/code_fetch_strobe.sv
module code_fetch_strobe
   import cfs_pkg::*;
#(
   parameter int PH_W         = 4,
   parameter int PC_W         = 16,
   parameter int CYCLE_PHASES = 12,
   parameter int NUM_PULSES   = 2,
   parameter int PULSE_OFFSET = 3,
   parameter int PULSE_LEN    = 3,
   parameter int ONCHIP_TOP   = 'h1FFF,
   parameter bit OUT_REG      = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PH_W-1:0] phase_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic            onchip_en_i,
   input  logic            xdata_cycle_i,
   output logic            fetch_strobe_n_o,
   output logic            fetch_offchip_o
);

   localparam logic [PH_W-1:0] PHASE_LIMIT = PH_W'(CYCLE_PHASES);

   phase_hits_t hits;
   fetch_src_e  src_now;
   fetch_src_e  src_q;
   fetch_src_e  src_win;

   cfs_phase_decode #(
      .PH_W         (PH_W),
      .CYCLE_PHASES (CYCLE_PHASES),
      .NUM_PULSES   (NUM_PULSES),
      .PULSE_OFFSET (PULSE_OFFSET),
      .PULSE_LEN    (PULSE_LEN)
   ) u_decode (
      .phase_i (phase_i),
      .hits_o  (hits)
   );

   cfs_source_select #(
      .PC_W       (PC_W),
      .ONCHIP_TOP (ONCHIP_TOP)
   ) u_select (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pc_i        (pc_i),
      .onchip_en_i (onchip_en_i),
      .eval_i      (hits.pulse_start),
      .src_now_o   (src_now),
      .src_q_o     (src_q)
   );

   // The first phase of a window uses the fresh decision, the rest the held one.
   assign src_win = hits.pulse_start ? src_now : src_q;

   cfs_strobe_gate #(
      .OUT_REG (OUT_REG)
   ) u_gate (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .in_window_i   (hits.in_window),
      .cycle_start_i (hits.cycle_start),
      .src_i         (src_win),
      .xdata_cycle_i (xdata_cycle_i),
      .strobe_n_o    (fetch_strobe_n_o)
   );

   assign fetch_offchip_o = (src_q == SRC_OFFCHIP);

   if (OUT_REG) begin : g_top_checks
      AST_LOW_MEANS_OFFCHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !fetch_strobe_n_o |-> fetch_offchip_o);                              // R4
      AST_LOW_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !fetch_strobe_n_o |-> $past(hits.in_window));                        // R2
      AST_SPARE_PHASE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (phase_i >= PHASE_LIMIT) |=> (fetch_strobe_n_o && $stable(fetch_offchip_o))); // R8
   end

   AST_RESET_IDLE: assert property (@(posedge clk_i)
      !rst_ni |=> (fetch_strobe_n_o && !fetch_offchip_o));                    // R1

endmodule

// File: tb/code_fetch_strobe_bench.sv
`timescale 1ns/1ps
module code_fetch_strobe_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  phase = 4'd0;
   logic [15:0] pc = 16'd0;
   logic        onchip_en = 1'b1;
   logic        xdata = 1'b0;
   logic        strobe_n;
   logic        offchip;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   code_fetch_strobe u_code_fetch_strobe (
      .clk_i            (clk),
      .rst_ni           (rst_n),
      .phase_i          (phase),
      .pc_i             (pc),
      .onchip_en_i      (onchip_en),
      .xdata_cycle_i    (xdata),
      .fetch_strobe_n_o (strobe_n),
      .fetch_offchip_o  (offchip)
   );

   function automatic bit goes_offchip(input logic [15:0] a, input bit en);
      return !en || (a > 16'h1FFF);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // One machine cycle; pa is presented for phases 0..5, pb for 6..11.
   task automatic run_cycle(input logic [15:0] pa, input logic [15:0] pb,
                            input bit en, input bit xd);
      bit    ext_a = goes_offchip(pa, en);
      bit    ext_b = goes_offchip(pb, en);
      int    falls = 0;
      int    exp_falls;
      bit    prev = 1'b1;
      string sreq;
      string dreq;
      sreq = xd ? "R3" : ((ext_a || ext_b) ? "R2" : "R4");
      dreq = (pa != pb) ? "R7" : (en ? "R5" : "R6");
      exp_falls = xd ? 0 : (int'(ext_a) + int'(ext_b));
      for (int p = 0; p < 12; p++) begin
         bit exp_low;
         @(negedge clk);
         phase     = 4'(p);
         pc        = (p < 6) ? pa : pb;
         onchip_en = en;
         xdata     = xd;
         @(posedge clk);
         #1;
         exp_low = !xd && (((p >= 3) && (p <= 5) && ext_a) ||
                           ((p >= 9) && (p <= 11) && ext_b));
         check(strobe_n == !exp_low, sreq, int'(strobe_n), int'(!exp_low));
         if (prev && !strobe_n) falls++;
         prev = strobe_n;
         if (p == 3) check(offchip == ext_a, dreq, int'(offchip), int'(ext_a));
         if (p == 9) check(offchip == ext_b, dreq, int'(offchip), int'(ext_b));
      end
      check(falls == exp_falls, sreq, falls, exp_falls);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20517));
      // R1: reset with a stimulus that would otherwise strobe
      onchip_en = 1'b0;
      phase     = 4'd3;
      repeat (3) @(posedge clk);
      #1;
      check(strobe_n == 1'b1, "R1", int'(strobe_n), 1);
      check(offchip == 1'b0, "R1", int'(offchip), 0);
      @(negedge clk);
      phase = 4'd0;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(strobe_n == 1'b1, "R1", int'(strobe_n), 1);
      check(offchip == 1'b0, "R1", int'(offchip), 0);

      // Directed corners
      run_cycle(16'h1FFF, 16'h1FFF, 1'b1, 1'b0);   // R5 last on-chip address
      run_cycle(16'h2000, 16'h2000, 1'b1, 1'b0);   // R5 first off-chip address, R2
      run_cycle(16'h0000, 16'h0000, 1'b0, 1'b0);   // R6 pin low, address 0
      run_cycle(16'h0100, 16'h0100, 1'b0, 1'b1);   // R3 data cycle suppresses both
      run_cycle(16'h1FFE, 16'h2001, 1'b1, 1'b0);   // R7 second window only
      run_cycle(16'hFFFF, 16'h0000, 1'b1, 1'b0);   // R7 first window only
      run_cycle(16'h0010, 16'h0010, 1'b1, 1'b0);   // R4 on-chip, no strobe

      // R8: spare phase codes, pin low would pick off-chip if sampled
      for (int s = 12; s < 16; s++) begin
         @(negedge clk);
         phase     = 4'(s);
         onchip_en = 1'b0;
         pc        = 16'hC000;
         @(posedge clk);
         #1;
         check(strobe_n == 1'b1, "R8", int'(strobe_n), 1);
         check(offchip == 1'b0, "R8", int'(offchip), 0);
      end

      // Random cycles biased toward the boundary
      for (int n = 0; n < 40; n++) begin
         logic [15:0] pa;
         logic [15:0] pb;
         bit          en;
         bit          xd;
         pa = ($urandom % 2 == 0) ? 16'(16'h1FFE + ($urandom % 4)) : 16'($urandom);
         pb = ($urandom % 3 == 0) ? 16'($urandom) : pa;
         en = ($urandom % 4) != 0;
         xd = ($urandom % 4) == 0;
         run_cycle(pa, pb, en, xd);
      end

      summary();
      $finish;
   end

endmodule